// File: doc/BRIEF.md
# Dual 8-bit Timer with Pulse Modes

This block holds two 8-bit up-counters, a lower and an upper, that share one mode setting. A 2-bit mode input gives four arrangements of the pair:

- two separate interval timers;
- one 16-bit timer, with the upper byte carried from the lower;
- a pulse generator that uses the lower counter, with both edges of the output set by the two compare values;
- a pulse-width modulator on the lower counter, with the upper counter left free as its own interval timer.

The counters do not divide the clock themselves. A prescaler outside the block supplies one-cycle tick enables at rates of 1, 1/4, 1/16 and 1/256. An external count input, taken on its rising edge, can also step the lower counter.

Each counter has a run input. While its run input is low, a counter is held at zero and its clock and mode settings may be changed. A setting changed while the counter runs is ignored until the next start. The block drives one timer flip-flop output. It also gives one interrupt pulse per counter and a flag that marks when the upper counter's flip-flop output is unused.

Top module: `dual_timer8`

## Requirements
- R1: Mode, PWM length and flip-flop source are captured only on clock edges where both run inputs are low. The lower clock select is captured only while run_lo is low, and the upper clock select only while run_hi is low. A change made while a counter runs has no effect until that counter is stopped and started again.
- R2: After reset every output is low. A counter whose run input is low is held at zero. The flip-flop output is low once every counter that can drive it is stopped: both counters in mode 00, the lower counter in the other modes.
- R3: The lower counter steps on its selected enable. lo_clk 00 selects a rising edge of ext_cnt, 01 selects tick1, 10 selects tick4 and 11 selects tick16.
- R4: Mode 00 has two interval timers. On a step where the lower count equals cmp_lo, the count clears and irq_lo is high for the cycle after that edge. The period is therefore cmp_lo+1 steps.
- R5: In mode 00 the upper counter behaves like the lower one against cmp_hi and raises irq_hi. It steps on hi_clk 00 = a lower counter match, 01 = tick1, 10 = tick16, 11 = tick256.
- R6: In mode 00 the flip-flop toggles on lower counter matches when ff_from_hi is 0, and on upper counter matches when ff_from_hi is 1.
- R7: Mode 01 has one 16-bit counter, with the upper byte carried from the lower byte and stepped by the lower clock. When the count equals {cmp_hi, cmp_lo}, both bytes clear, irq_hi pulses and the flip-flop toggles.
- R8: Mode 10 is the pulse generator. The upper counter stays at zero. A step at count cmp_hi clears the count, toggles the flip-flop and pulses irq_hi. Otherwise a step at count cmp_lo toggles the flip-flop and pulses irq_lo.
- R9: Mode 11 is the PWM. The lower count runs over a period of 64, 128 or 256 steps for pwm_len 01, 10 or 11. irq_lo pulses on the step that wraps the count to zero.
- R10: In mode 11 the output is high exactly while the lower counter runs and its count is below a duty buffer. The buffer loads cmp_lo while run_lo is low and on each wrap. A duty of 0 keeps the output low, and a duty of at least the period keeps it high.
- R11: In mode 11 with pwm_len 00 the lower counter does not step, and the output and irq_lo stay low.
- R12: In mode 11 out_disable is high. The upper counter is a separate interval timer against cmp_hi with irq_hi, stepped by hi_clk 01 = tick1, 10 = tick16, 11 = tick256. With hi_clk 00 it does not step. Its matches never touch the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick1 | input | 1 | Prescaler enable, every cycle rate |
| tick4 | input | 1 | Prescaler enable, 1/4 rate |
| tick16 | input | 1 | Prescaler enable, 1/16 rate |
| tick256 | input | 1 | Prescaler enable, 1/256 rate |
| ext_cnt | input | 1 | External count input, rising edge counts |
| mode | input | 2 | Counter arrangement select |
| lo_clk | input | 2 | Lower counter clock select |
| hi_clk | input | 2 | Upper counter clock select |
| pwm_len | input | 2 | PWM period select |
| ff_from_hi | input | 1 | Flip-flop toggle source in mode 00 |
| cmp_lo | input | 8 | Lower compare value / PWM duty |
| cmp_hi | input | 8 | Upper compare value |
| run_lo | input | 1 | Run enable of the lower counter |
| run_hi | input | 1 | Run enable of the upper counter |
| tff_out | output | 1 | Timer flip-flop / PWM output |
| irq_lo | output | 1 | Lower counter event pulse |
| irq_hi | output | 1 | Upper counter event pulse |
| out_disable | output | 1 | Upper flip-flop output unused (mode 11) |

## Verification
The counts are hidden, so a wrong count or latched setting shows only as an interrupt pulse or a flip-flop edge on the wrong cycle. In interval modes it surfaces at the next match, within cmp+1 steps. In PWM mode it surfaces at the next duty crossing or wrap, within one period. A duty buffer loaded at the wrong time moves the falling edge of the output in the period that follows the change. A setting that leaks in while a counter runs changes the interrupt spacing at once. The bench keeps its own cycle model of the counts and compares all four outputs on every cycle, so any of these faults is flagged on the first cycle where an output differs.

// File: rtl/dual_timer8.sv
module dual_timer8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick1,
  input  logic       tick4,
  input  logic       tick16,
  input  logic       tick256,
  input  logic       ext_cnt,
  input  logic [1:0] mode,
  input  logic [1:0] lo_clk,
  input  logic [1:0] hi_clk,
  input  logic [1:0] pwm_len,
  input  logic       ff_from_hi,
  input  logic [7:0] cmp_lo,
  input  logic [7:0] cmp_hi,
  input  logic       run_lo,
  input  logic       run_hi,
  output logic       tff_out,
  output logic       irq_lo,
  output logic       irq_hi,
  output logic       out_disable
);

  localparam logic [1:0] M_DUAL = 2'd0;
  localparam logic [1:0] M_WIDE = 2'd1;
  localparam logic [1:0] M_PPG  = 2'd2;
  localparam logic [1:0] M_PWM  = 2'd3;

  logic [1:0] mode_q, lo_sel_q, hi_sel_q, len_q;
  logic       ffsel_q, ext_q;
  logic [7:0] lo_cnt, hi_cnt, duty_q;
  logic       tff_q, irq_lo_q, irq_hi_q;

  logic [7:0] lo_n, hi_n, duty_n, last;
  logic       tff_n, mlo, mhi, tick_lo, tick_hi;

  wire idle     = ~run_lo & ~run_hi;
  wire ext_edge = ext_cnt & ~ext_q;

  assign last = (len_q == 2'd1) ? 8'd63 : (len_q == 2'd2) ? 8'd127 : 8'd255;

  always_comb begin
    case (lo_sel_q)
      2'd0:    tick_lo = ext_edge;
      2'd1:    tick_lo = tick1;
      2'd2:    tick_lo = tick4;
      default: tick_lo = tick16;
    endcase
  end

  always_comb begin
    lo_n    = lo_cnt;
    hi_n    = hi_cnt;
    duty_n  = run_lo ? duty_q : cmp_lo;
    tff_n   = tff_q;
    mlo     = 1'b0;
    mhi     = 1'b0;
    tick_hi = 1'b0;

    case (mode_q)
      M_DUAL: begin
        if (!run_lo) lo_n = 8'd0;
        else if (tick_lo) begin
          if (lo_cnt == cmp_lo) begin
            lo_n = 8'd0;
            mlo  = 1'b1;
          end else lo_n = lo_cnt + 8'd1;
        end
      end
      M_WIDE: begin
        if (!run_lo) begin
          {hi_n, lo_n} = 16'd0;
          tff_n = 1'b0;
        end else if (tick_lo) begin
          if ({hi_cnt, lo_cnt} == {cmp_hi, cmp_lo}) begin
            {hi_n, lo_n} = 16'd0;
            mhi   = 1'b1;
            tff_n = ~tff_q;
          end else {hi_n, lo_n} = {hi_cnt, lo_cnt} + 16'd1;
        end
      end
      M_PPG: begin
        hi_n = 8'd0;
        if (!run_lo) begin
          lo_n  = 8'd0;
          tff_n = 1'b0;
        end else if (tick_lo) begin
          if (lo_cnt == cmp_hi) begin
            lo_n  = 8'd0;
            mhi   = 1'b1;
            tff_n = ~tff_q;
          end else begin
            lo_n = lo_cnt + 8'd1;
            if (lo_cnt == cmp_lo) begin
              mlo   = 1'b1;
              tff_n = ~tff_q;
            end
          end
        end
      end
      default: begin
        if (!run_lo) lo_n = 8'd0;
        else if (len_q != 2'd0 && tick_lo) begin
          if (lo_cnt == last) begin
            lo_n   = 8'd0;
            duty_n = cmp_lo;
            mlo    = 1'b1;
          end else lo_n = lo_cnt + 8'd1;
        end
        tff_n = run_lo && (len_q != 2'd0) && (lo_n < duty_n);
      end
    endcase

    if (mode_q == M_DUAL || mode_q == M_PWM) begin
      case (hi_sel_q)
        2'd0:    tick_hi = (mode_q == M_DUAL) & mlo;
        2'd1:    tick_hi = tick1;
        2'd2:    tick_hi = tick16;
        default: tick_hi = tick256;
      endcase
      if (!run_hi) hi_n = 8'd0;
      else if (tick_hi) begin
        if (hi_cnt == cmp_hi) begin
          hi_n = 8'd0;
          mhi  = 1'b1;
        end else hi_n = hi_cnt + 8'd1;
      end
    end

    if (mode_q == M_DUAL) begin
      if (idle) tff_n = 1'b0;
      else if (ffsel_q ? mhi : mlo) tff_n = ~tff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'd0;
      lo_sel_q <= 2'd0;
      hi_sel_q <= 2'd0;
      len_q    <= 2'd0;
      ffsel_q  <= 1'b0;
      ext_q    <= 1'b0;
      lo_cnt   <= 8'd0;
      hi_cnt   <= 8'd0;
      duty_q   <= 8'd0;
      tff_q    <= 1'b0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      if (idle) begin
        mode_q  <= mode;
        len_q   <= pwm_len;
        ffsel_q <= ff_from_hi;
      end
      if (!run_lo) lo_sel_q <= lo_clk;
      if (!run_hi) hi_sel_q <= hi_clk;
      ext_q    <= ext_cnt;
      lo_cnt   <= lo_n;
      hi_cnt   <= hi_n;
      duty_q   <= duty_n;
      tff_q    <= tff_n;
      irq_lo_q <= mlo;
      irq_hi_q <= mhi;
    end
  end

  assign tff_out     = tff_q;
  assign irq_lo      = irq_lo_q;
  assign irq_hi      = irq_hi_q;
  assign out_disable = (mode_q == M_PWM);

  a_r2_lo_held_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lo |=> (lo_cnt == 8'd0));

  a_r2_ff_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !tff_q);

  a_r7_carry_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WIDE && hi_cnt != 8'd0 && hi_cnt != $past(hi_cnt)) |-> ($past(lo_cnt) == 8'hFF));

  a_r8_upper_idle_in_ppg: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PPG) |-> (hi_cnt == 8'd0));

  a_r9_pwm_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM) |-> (lo_cnt <= last));

  a_r10_pwm_high_below_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM && tff_q) |-> (lo_cnt < duty_q));

endmodule

// File: tb/dual_timer8_tb.sv
`timescale 1ns/1ps
module dual_timer8_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick1 = 1'b0, tick4 = 1'b0, tick16 = 1'b0, tick256 = 1'b0, ext_cnt = 1'b0;
  logic [1:0] mode = 2'd0, lo_clk = 2'd0, hi_clk = 2'd0, pwm_len = 2'd0;
  logic ff_from_hi = 1'b0;
  logic [7:0] cmp_lo = 8'd0, cmp_hi = 8'd0;
  logic run_lo = 1'b0, run_hi = 1'b0;
  logic tff_out, irq_lo, irq_hi, out_disable;

  int vectors = 0, errors = 0, pc = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string tag = "R2";

  int m_mode = 0, m_lsel = 0, m_hsel = 0, m_len = 0, m_lo = 0, m_hi = 0, m_duty = 0;
  bit m_ffs = 0, m_tff = 0, m_ilo = 0, m_ihi = 0, m_ext = 0;

  always #2.5 clk = ~clk;

  dual_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .tick1(tick1), .tick4(tick4), .tick16(tick16),
    .tick256(tick256), .ext_cnt(ext_cnt), .mode(mode), .lo_clk(lo_clk),
    .hi_clk(hi_clk), .pwm_len(pwm_len), .ff_from_hi(ff_from_hi),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .run_lo(run_lo), .run_hi(run_hi),
    .tff_out(tff_out), .irq_lo(irq_lo), .irq_hi(irq_hi), .out_disable(out_disable));

  task automatic model();
    bit el, tl, th, mlo, mhi;
    int per, v;
    el = ext_cnt && !m_ext;
    m_ext = ext_cnt;
    case (m_lsel) 0: tl = el; 1: tl = tick1; 2: tl = tick4; default: tl = tick16; endcase
    mlo = 0; mhi = 0; th = 0;
    if (!run_lo) m_duty = cmp_lo;
    case (m_mode)
      0: begin
        if (!run_lo) m_lo = 0;
        else if (tl) begin
          if (m_lo == cmp_lo) begin m_lo = 0; mlo = 1; end else m_lo++;
        end
      end
      1: begin
        v = m_hi * 256 + m_lo;
        if (!run_lo) begin v = 0; m_tff = 0; end
        else if (tl) begin
          if (v == cmp_hi * 256 + cmp_lo) begin v = 0; mhi = 1; m_tff = !m_tff; end
          else v = (v + 1) % 65536;
        end
        m_hi = v / 256; m_lo = v % 256;
      end
      2: begin
        m_hi = 0;
        if (!run_lo) begin m_lo = 0; m_tff = 0; end
        else if (tl) begin
          if (m_lo == cmp_hi) begin m_lo = 0; mhi = 1; m_tff = !m_tff; end
          else begin
            if (m_lo == cmp_lo) begin mlo = 1; m_tff = !m_tff; end
            m_lo++;
          end
        end
      end
      default: begin
        per = 32 << m_len;
        if (!run_lo) m_lo = 0;
        else if (m_len != 0 && tl) begin
          m_lo++;
          if (m_lo == per) begin m_lo = 0; m_duty = cmp_lo; mlo = 1; end
        end
        m_tff = run_lo && m_len != 0 && m_lo < m_duty;
      end
    endcase
    if (m_mode == 0 || m_mode == 3) begin
      case (m_hsel)
        0: th = (m_mode == 0) && mlo;
        1: th = tick1;
        2: th = tick16;
        default: th = tick256;
      endcase
      if (!run_hi) m_hi = 0;
      else if (th) begin
        if (m_hi == cmp_hi) begin m_hi = 0; mhi = 1; end else m_hi++;
      end
    end
    if (m_mode == 0) begin
      if (!run_lo && !run_hi) m_tff = 0;
      else if (m_ffs ? mhi : mlo) m_tff = !m_tff;
    end
    m_ilo = mlo; m_ihi = mhi;
    if (!run_lo && !run_hi) begin m_mode = mode; m_len = pwm_len; m_ffs = ff_from_hi; end
    if (!run_lo) m_lsel = lo_clk;
    if (!run_hi) m_hsel = hi_clk;
  endtask

  task automatic compare();
    bit exp_dis;
    exp_dis = (m_mode == 3);
    vectors++;
    if (tff_out !== m_tff || irq_lo !== m_ilo || irq_hi !== m_ihi || out_disable !== exp_dis) begin
      errors++;
      $display("FAIL %s cycle %0d: tff/irq_lo/irq_hi/dis got %b%b%b%b expected %b%b%b%b",
               tag, pc, tff_out, irq_lo, irq_hi, out_disable, m_tff, m_ilo, m_ihi, exp_dis);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    pc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick1 = 1'b1;
    tick4 = (pc % 4) == 0;
    tick16 = (pc % 16) == 0;
    tick256 = (pc % 256) == 0;
    ext_cnt = lfsr[0];
  endtask

  task automatic go(input string t, input int n);
    tag = t;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic stop_all();
    run_lo = 0; run_hi = 0;
    go("R2", 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (tff_out !== 0 || irq_lo !== 0 || irq_hi !== 0 || out_disable !== 0) begin
      errors++;
      $display("FAIL R2 reset outputs got %b%b%b%b expected 0000", tff_out, irq_lo, irq_hi, out_disable);
    end
    rst_n = 1'b1;
    go("R2", 4);

    // R3 R4: each lower clock source, interval timer
    for (int s = 0; s < 4; s++) begin
      mode = 0; lo_clk = s[1:0]; cmp_lo = 8'd5; ff_from_hi = 0;
      go("R3", 2);
      run_lo = 1;
      go("R4", 300);
      stop_all();
    end
    mode = 0; lo_clk = 1; cmp_lo = 8'd0; go("R4", 2); run_lo = 1; go("R4", 20); stop_all();

    // R5 R6: upper clock sources and flip-flop source
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 2; f++) begin
        mode = 0; lo_clk = 1; hi_clk = s[1:0]; ff_from_hi = f[0]; cmp_lo = 8'd3; cmp_hi = 8'd2;
        go("R5", 2);
        run_lo = 1; run_hi = 1;
        go(f ? "R6" : "R5", (s == 3) ? 1600 : 120);
        stop_all();
      end
    end

    // R1: changes while running are ignored until restart
    mode = 0; lo_clk = 1; hi_clk = 1; cmp_lo = 8'd4; cmp_hi = 8'd6; ff_from_hi = 0;
    go("R1", 2); run_lo = 1; run_hi = 1; go("R1", 10);
    mode = 3; pwm_len = 1; lo_clk = 2; hi_clk = 3; ff_from_hi = 1;
    go("R1", 60);
    run_hi = 0; go("R1", 40);
    run_lo = 0; go("R1", 3); run_lo = 1; go("R1", 200);
    stop_all();

    // R7: 16-bit cascade
    mode = 1; lo_clk = 1; cmp_hi = 8'h01; cmp_lo = 8'h03; go("R7", 2);
    run_lo = 1; go("R7", 900); stop_all();
    cmp_hi = 8'h00; cmp_lo = 8'h00; go("R7", 1); run_lo = 1; go("R7", 10); stop_all();
    cmp_hi = 8'h00; cmp_lo = 8'h07; lo_clk = 2; go("R7", 1); run_lo = 1; go("R7", 100); stop_all();

    // R8: pulse generator
    mode = 2; lo_clk = 1; cmp_lo = 8'd3; cmp_hi = 8'd9; go("R8", 2); run_lo = 1; run_hi = 1; go("R8", 100); stop_all();
    cmp_lo = 8'd5; cmp_hi = 8'd5; go("R8", 1); run_lo = 1; go("R8", 60); stop_all();
    cmp_lo = 8'd12; cmp_hi = 8'd4; lo_clk = 0; go("R8", 1); run_lo = 1; go("R8", 200); stop_all();

    // R9 R10: PWM lengths and duties
    for (int l = 1; l < 4; l++) begin
      mode = 3; pwm_len = l[1:0]; lo_clk = 1; cmp_lo = 8'd20;
      go("R9", 2); run_lo = 1; go("R9", 600); stop_all();
    end
    mode = 3; pwm_len = 1; cmp_lo = 8'd0; go("R10", 1); run_lo = 1; go("R10", 150); stop_all();
    cmp_lo = 8'd200; go("R10", 1); run_lo = 1; go("R10", 150); stop_all();
    pwm_len = 2; cmp_lo = 8'd30; go("R10", 1); run_lo = 1; go("R10", 40);
    cmp_lo = 8'd90; go("R10", 300); cmp_lo = 8'd10; go("R10", 300); stop_all();
    pwm_len = 3; lo_clk = 2; cmp_lo = 8'd255; go("R10", 1); run_lo = 1; go("R10", 2200); stop_all();

    // R11: invalid PWM length
    mode = 3; pwm_len = 0; lo_clk = 1; cmp_lo = 8'd10; go("R11", 2); run_lo = 1; go("R11", 200); stop_all();

    // R12: upper timer beside PWM
    for (int s = 0; s < 4; s++) begin
      mode = 3; pwm_len = 1; lo_clk = 1; cmp_lo = 8'd16; hi_clk = s[1:0]; cmp_hi = 8'd1;
      go("R12", 2); run_lo = 1; run_hi = 1; go("R12", (s == 3) ? 1100 : 200); stop_all();
    end
    run_hi = 1; go("R12", 100); stop_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule